// File: doc/BRIEF.md
# Interrupt Control Register File

This block keeps the interrupt state of a small processor core and decides when the core must take an interrupt. Up to `N_SRC` device request lines arrive here. Each line is already qualified by the enable bit inside its own device. The block samples these lines into a per-source pending vector. It also keeps a per-source mask, a status word whose bit 0 is the global interrupt enable, and a shadow copy of that status word.

Software reaches the four registers with indexed control-register moves over a single read/write port. The read path is combinational from the index. A write lands on the next clock edge.

The core receives a combinational take signal. When the core starts the handler, it pulses an entry strobe. On that edge the block saves the status word into the shadow and clears the global enable, so a second request cannot re-enter. When the handler ends, the core pulses a return strobe and the status word is restored from the shadow.

Top module: `intr_ctl_regs`

## Requirements
- R1: After reset, the status word, the shadow word and the mask all read zero, and the take output is low.
- R2: The pending register is at index 4. On every clock edge, pending bit i loads device request line i, so a read shows the request lines as they were one edge earlier. A write to index 4 changes nothing.
- R3: The mask register is at index 3. Bits [N_SRC-1:0] are written from the write data, and bits at N_SRC and above read zero.
- R4: The take output is high exactly when status bit 0 is 1 and at least one source has both its pending bit and its mask bit set. The output is computed combinationally from the stored registers.
- R5: On an edge where the entry strobe is high, the shadow word loads the current status word, and status bit 0 becomes 0 while the other status bits keep their values.
- R6: On an edge where the return strobe is high and the entry strobe is low, the status word loads the shadow word.
- R7: On an edge where either strobe is high, a software write to the status word (index 0) or to the shadow word (index 1) is dropped. Mask writes in that cycle still take effect.
- R8: The status word is at index 0 and the shadow word at index 1, both STAT_W bits wide and zero-extended on read. Indices 2, 5, 6 and 7 read zero, and writes to them change no register.
- R9: If both strobes are high on the same edge, the entry behaviour of R5 applies and the return strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req_i | input | N_SRC | Device request lines, already gated by each device's own enable |
| csr_idx_i | input | 3 | Control register index |
| csr_we_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | XLEN | Control register write data |
| csr_rdata_o | output | XLEN | Control register read data, combinational from the index |
| enter_i | input | 1 | Handler entry strobe from the core |
| ret_i | input | 1 | Handler return strobe from the core |
| irq_take_o | output | 1 | Interrupt should be taken |

## Verification
The bench builds the block with N_SRC = 5, XLEN = 16 and STAT_W = 4. With a mask narrower than the data word, the zero upper bits of the mask and pending reads (R2, R3) become observable. The narrow status word lets random writes reach every status pattern, with the global enable both set and clear. Random strobes mixed with random control writes regularly land entry, return and status writes on the same edge, which exercises the precedence rules of R7 and R9.

// File: rtl/intr_ctl_pkg.sv
package intr_ctl_pkg;
    localparam int IDX_W       = 3;
    localparam int IDX_STATUS  = 0;
    localparam int IDX_SHADOW  = 1;
    localparam int IDX_MASK    = 3;
    localparam int IDX_PENDING = 4;
    localparam int GIE_BIT     = 0;
endpackage

// File: rtl/intr_ctl_pending.sv
module intr_ctl_pending #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2
    pend_tracks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_o == $past(req_i));
endmodule

// File: rtl/intr_ctl_state.sv
module intr_ctl_state
    import intr_ctl_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int XLEN   = 32,
    parameter int STAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             we_i,
    input  logic [XLEN-1:0]  wdata_i,
    input  logic             enter_i,
    input  logic             ret_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] shadow_o,
    output logic [N_SRC-1:0]  mask_o
);
    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] shadow;
        logic [N_SRC-1:0]  mask;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       strobe;
    logic       wr_status, wr_shadow, wr_mask;

    always_comb begin
        strobe    = enter_i | ret_i;
        wr_status = we_i && (int'(idx_i) == IDX_STATUS);
        wr_shadow = we_i && (int'(idx_i) == IDX_SHADOW);
        wr_mask   = we_i && (int'(idx_i) == IDX_MASK);

        st_d = st_q;
        if (wr_mask) st_d.mask = wdata_i[N_SRC-1:0];

        if (enter_i) begin
            st_d.shadow          = st_q.status;
            st_d.status          = st_q.status;
            st_d.status[GIE_BIT] = 1'b0;
        end else if (ret_i) begin
            st_d.status = st_q.shadow;
        end

        if (!strobe) begin
            if (wr_status) st_d.status = wdata_i[STAT_W-1:0];
            if (wr_shadow) st_d.shadow = wdata_i[STAT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign shadow_o = st_q.shadow;
    assign mask_o   = st_q.mask;

    // R5
    entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> !status_o[GIE_BIT]);
    // R5
    entry_saves_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> shadow_o == $past(status_o));
    // R6
    return_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !enter_i) |=> status_o == $past(shadow_o));
    // R7
    strobe_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && we_i && int'(idx_i) == IDX_STATUS) |=> !status_o[GIE_BIT]);
endmodule

// File: rtl/intr_ctl_rdmux.sv
module intr_ctl_rdmux
    import intr_ctl_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int XLEN   = 32,
    parameter int STAT_W = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic [STAT_W-1:0] shadow_i,
    input  logic [N_SRC-1:0]  mask_i,
    input  logic [N_SRC-1:0]  pend_i,
    output logic [XLEN-1:0]   rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (int'(idx_i))
            IDX_STATUS:  rdata_o[STAT_W-1:0] = status_i;
            IDX_SHADOW:  rdata_o[STAT_W-1:0] = shadow_i;
            IDX_MASK:    rdata_o[N_SRC-1:0]  = mask_i;
            IDX_PENDING: rdata_o[N_SRC-1:0]  = pend_i;
            default:     rdata_o             = '0;
        endcase
    end
endmodule

// File: rtl/intr_ctl_regs.sv
module intr_ctl_regs
    import intr_ctl_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int XLEN   = 32,
    parameter int STAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] dev_req_i,
    input  logic [2:0]       csr_idx_i,
    input  logic             csr_we_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    input  logic             enter_i,
    input  logic             ret_i,
    output logic             irq_take_o
);
    logic [STAT_W-1:0] status, shadow;
    logic [N_SRC-1:0]  mask, pend;

    intr_ctl_pending #(.N_SRC(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (dev_req_i),
        .pend_o (pend)
    );

    intr_ctl_state #(.N_SRC(N_SRC), .XLEN(XLEN), .STAT_W(STAT_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_i    (csr_idx_i),
        .we_i     (csr_we_i),
        .wdata_i  (csr_wdata_i),
        .enter_i  (enter_i),
        .ret_i    (ret_i),
        .status_o (status),
        .shadow_o (shadow),
        .mask_o   (mask)
    );

    intr_ctl_rdmux #(.N_SRC(N_SRC), .XLEN(XLEN), .STAT_W(STAT_W)) u_rd (
        .idx_i    (csr_idx_i),
        .status_i (status),
        .shadow_i (shadow),
        .mask_i   (mask),
        .pend_i   (pend),
        .rdata_o  (csr_rdata_o)
    );

    assign irq_take_o = status[GIE_BIT] & (|(pend & mask));

    // R4
    take_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_o |-> ($past(dev_req_i) & mask) != '0);
    // R9
    entry_beats_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && ret_i) |=> !irq_take_o);
endmodule

// File: tb/intr_ctl_regs_test.sv
module intr_ctl_regs_test;
    localparam int N  = 5;
    localparam int XL = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_req = '0;
    logic [2:0]    idx = '0;
    logic          we = 1'b0;
    logic [XL-1:0] wdata = '0;
    logic [XL-1:0] rdata;
    logic          enter = 1'b0, ret = 1'b0;
    logic          take;

    int n_chk = 0, n_fail = 0;
    logic [SW-1:0] m_status = '0, m_shadow = '0;
    logic [N-1:0]  m_mask = '0, m_pend = '0;

    intr_ctl_regs #(.N_SRC(N), .XLEN(XL), .STAT_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .dev_req_i(dev_req), .csr_idx_i(idx),
        .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .enter_i(enter), .ret_i(ret), .irq_take_o(take)
    );

    always #4 clk = ~clk;

    function automatic logic [XL-1:0] exp_rd(input logic [2:0] i);
        logic [XL-1:0] r = '0;
        case (i)
            3'd0: r[SW-1:0] = m_status;
            3'd1: r[SW-1:0] = m_shadow;
            3'd3: r[N-1:0]  = m_mask;
            3'd4: r[N-1:0]  = m_pend;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic exp_take();
        return m_status[0] & (|(m_pend & m_mask));
    endfunction

    task automatic chk(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model update for one edge, evaluated with the values in force before it.
    task automatic model_edge();
        logic strobe = enter | ret;
        if (we && idx == 3'd3) m_mask = wdata[N-1:0];
        if (enter) begin
            m_shadow = m_status;
            m_status[0] = 1'b0;
        end else if (ret) begin
            m_status = m_shadow;
        end
        if (!strobe && we && idx == 3'd0) m_status = wdata[SW-1:0];
        if (!strobe && we && idx == 3'd1) m_shadow = wdata[SW-1:0];
        m_pend = dev_req;
    endtask

    // Inputs are set at a negedge; check outputs, then cross one posedge.
    task automatic step(input string req);
        #1;
        chk({req, " rdata"}, rdata, exp_rd(idx));
        chk({req, " take"}, {{(XL-1){1'b0}}, take}, {{(XL-1){1'b0}}, exp_take()});
        @(posedge clk);
        model_edge();
        @(negedge clk);
        we = 1'b0; enter = 1'b0; ret = 1'b0;
    endtask

    task automatic wr(input logic [2:0] i, input logic [XL-1:0] d, input string req);
        idx = i; we = 1'b1; wdata = d;
        step(req);
    endtask

    task automatic rd(input logic [2:0] i, input string req);
        idx = i;
        step(req);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd3, "R1");
        // R3 mask write, upper bits zero
        wr(3'd3, 16'hFFFF, "R3"); rd(3'd3, "R3");
        // R2 pending follows requests; writes ignored
        dev_req = 5'b10010; rd(3'd4, "R2");
        wr(3'd4, 16'h0000, "R2"); rd(3'd4, "R2");
        // R8 unmapped index reads zero, write ignored
        wr(3'd2, 16'hFFFF, "R8"); rd(3'd2, "R8"); rd(3'd6, "R8");
        // R4 enable globally -> take
        wr(3'd0, 16'h000B, "R4"); rd(3'd0, "R4");
        // R5 entry saves and clears
        enter = 1'b1; rd(3'd0, "R5"); rd(3'd1, "R5");
        // R6 return restores
        ret = 1'b1; rd(3'd0, "R6"); rd(3'd0, "R6");
        // R7 entry with status write in same cycle
        idx = 3'd0; we = 1'b1; wdata = 16'h000F; enter = 1'b1; step("R7");
        rd(3'd0, "R7"); rd(3'd1, "R7");
        // R9 both strobes together
        wr(3'd0, 16'h0005, "R9");
        enter = 1'b1; ret = 1'b1; rd(3'd0, "R9"); rd(3'd1, "R9");
        // R4 request dropped -> take falls
        dev_req = '0; rd(3'd4, "R4"); rd(3'd0, "R4");
        // Random mix
        for (int k = 0; k < 400; k++) begin
            dev_req = N'($urandom);
            idx     = 3'($urandom);
            we      = ($urandom % 3) == 0;
            wdata   = XL'($urandom);
            enter   = ($urandom % 8) == 0;
            ret     = ($urandom % 8) == 0;
            step("R4/R5/R6/R7 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule